// File: doc/BRIEF.md
# Analog Input Multiplexer Address Decoder

This block turns the four-bit channel-selection word that a converter's serial controller has captured into enables for an analog input multiplexer. The multiplexer has a positive bus, a negative bus and a common line. There is one enable per channel on each bus, plus one enable that routes the common line onto the negative bus. In single-ended mode the addressed channel goes to the positive bus and the common line supplies the negative side. In differential mode two neighbouring channels, an even one and the odd one above it, are placed across the two buses. A sign bit in the word decides which of the two is positive.

A parameter selects between an eight-channel build and a four-channel build. The four-channel build does not use the upper select bit, and its common line is grounded inside the part. A word that sets the unused bit is reported as illegal, and no switch closes for it. The controller pulses `load` for one cycle when it has captured a complete word. The decoded enables are registered on that edge and hold until the next load, so the routing can change on every conversion. Before the first load after reset, every switch stays open.

Top module: `mux_addr_decoder`

## Requirements
- R1: Reset is synchronous and active high. While it is asserted, and afterwards until the first `load`, `pos_en`, `neg_en`, `com_neg` and `addr_bad` are all zero.
- R2: In the eight-channel build, a word with bit 3 set selects single-ended mode. The channel number is {bit1, bit0, bit2}. `pos_en` has only that channel's bit set, `com_neg` is 1 and `neg_en` is zero.
- R3: In the eight-channel build, a word with bit 3 clear selects differential mode on pair p = {bit1, bit0}. With bit 2 clear, channel 2p is positive and 2p+1 is negative. With bit 2 set, the two are swapped. `com_neg` is 0.
- R4: Outputs take the value decoded from `mux_word` in the first cycle after a rising clock edge at which `load` is high. At any edge where `load` is low, the word is ignored and all outputs hold.
- R5: `pos_en` and `neg_en` each have at most one bit set, and they never enable the same channel.
- R6: In the four-channel build, bit 1 must be zero. If it is set, `addr_bad` is 1 and all enables are zero. Otherwise `addr_bad` is 0, the single-ended channel is {bit0, bit2} and the differential pair is bit0, with polarity as in R3.
- R7: A legal word loaded after an illegal one clears `addr_bad` and applies its own routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | One-cycle strobe: a complete word is present on `mux_word` |
| mux_word | input | 4 | {single-ended, sign/odd, select1, select0} |
| pos_en | output | NCH | One-hot enable of the channel switched onto the positive bus |
| neg_en | output | NCH | One-hot enable of the channel switched onto the negative bus |
| com_neg | output | 1 | Common line switched onto the negative bus |
| addr_bad | output | 1 | Last loaded word is not legal for this build |

## Verification
Every result is due exactly one cycle after the edge that samples `load`. The same edge also holds the results when `load` is low. The bench drives inputs on the falling edge. Its reference model updates on the rising edge, as a register would, and it compares all four outputs of both builds at the following falling edge. This way each comparison sees the value settled by exactly one edge. Between loads, the bench changes `mux_word` to its complement to show that unloaded words do not reach the outputs.

// File: rtl/mux_dec_pkg.sv
package mux_dec_pkg;

    localparam int MAX_CH   = 8;
    localparam int CH_IDX_W = $clog2(MAX_CH);

    typedef enum logic {
        MODE_DIFF   = 1'b0,
        MODE_SINGLE = 1'b1
    } in_mode_e;

    typedef struct packed {
        in_mode_e   mode;
        logic       sign;
        logic [1:0] sel;
    } mux_word_t;

    typedef struct packed {
        logic                pos_vld;
        logic [CH_IDX_W-1:0] pos_idx;
        logic                neg_vld;
        logic [CH_IDX_W-1:0] neg_idx;
        logic                com_neg;
        logic                bad;
    } route_t;

    function automatic route_t route_idle();
        route_t r;
        r = '0;
        return r;
    endfunction

    // Differential route for pair index p; sign picks the odd member as positive.
    function automatic route_t route_pair(logic [CH_IDX_W-2:0] p, logic sign);
        route_t r;
        r         = '0;
        r.pos_vld = 1'b1;
        r.neg_vld = 1'b1;
        r.pos_idx = {p, sign};
        r.neg_idx = {p, ~sign};
        return r;
    endfunction

    // Single-ended route: channel positive, common line negative.
    function automatic route_t route_single(logic [CH_IDX_W-1:0] ch);
        route_t r;
        r         = '0;
        r.pos_vld = 1'b1;
        r.pos_idx = ch;
        r.com_neg = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/mux_word_decode.sv
module mux_word_decode
    import mux_dec_pkg::*;
#(
    parameter int NCH = 8
) (
    input  mux_word_t word,
    output route_t    route
);

    generate
        if (NCH == 4) begin : g_four
            always_comb begin
                if (word.sel[1]) begin
                    route     = route_idle();
                    route.bad = 1'b1;
                end else if (word.mode == MODE_SINGLE) begin
                    route = route_single({1'b0, word.sel[0], word.sign});
                end else begin
                    route = route_pair({1'b0, word.sel[0]}, word.sign);
                end
            end
        end else begin : g_eight
            always_comb begin
                if (word.mode == MODE_SINGLE) begin
                    route = route_single({word.sel, word.sign});
                end else begin
                    route = route_pair(word.sel, word.sign);
                end
            end
        end
    endgenerate

    always_comb begin
        if (!route.bad) begin
            assert_pair_adjacent_R3: assert (!(route.pos_vld && route.neg_vld) ||
                (route.pos_idx[CH_IDX_W-1:1] == route.neg_idx[CH_IDX_W-1:1] &&
                 route.pos_idx[0] != route.neg_idx[0]));
        end
    end

endmodule

// File: rtl/mux_enable_reg.sv
module mux_enable_reg
    import mux_dec_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  route_t         route,
    output logic [NCH-1:0] pos_en,
    output logic [NCH-1:0] neg_en,
    output logic           com_neg,
    output logic           addr_bad
);

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            always_ff @(posedge clk) begin
                if (rst) begin
                    pos_en[i] <= 1'b0;
                    neg_en[i] <= 1'b0;
                end else if (load) begin
                    pos_en[i] <= route.pos_vld && (int'(route.pos_idx) == i);
                    neg_en[i] <= route.neg_vld && (int'(route.neg_idx) == i);
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            com_neg  <= 1'b0;
            addr_bad <= 1'b0;
        end else if (load) begin
            com_neg  <= route.com_neg;
            addr_bad <= route.bad;
        end
    end

    assert_pos_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pos_en));
    assert_neg_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(neg_en));
    assert_no_overlap_R5: assert property (@(posedge clk) disable iff (rst)
        (pos_en & neg_en) == '0);
    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(pos_en) && $stable(neg_en) && $stable(com_neg) && $stable(addr_bad));
    assert_com_alone_R2: assert property (@(posedge clk) disable iff (rst)
        com_neg |-> (neg_en == '0) && $countones(pos_en) == 1);
    assert_bad_closed_R6: assert property (@(posedge clk) disable iff (rst)
        addr_bad |-> (pos_en == '0) && (neg_en == '0) && !com_neg);

endmodule

// File: rtl/mux_addr_decoder.sv
module mux_addr_decoder
    import mux_dec_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [3:0]     mux_word,
    output logic [NCH-1:0] pos_en,
    output logic [NCH-1:0] neg_en,
    output logic           com_neg,
    output logic           addr_bad
);

    mux_word_t word_s;
    route_t    route_s;

    assign word_s = mux_word_t'(mux_word);

    mux_word_decode #(.NCH(NCH)) u_decode (
        .word  (word_s),
        .route (route_s)
    );

    mux_enable_reg #(.NCH(NCH)) u_enables (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .route    (route_s),
        .pos_en   (pos_en),
        .neg_en   (neg_en),
        .com_neg  (com_neg),
        .addr_bad (addr_bad)
    );

    initial begin
        assert_variant_R6: assert (NCH == 4 || NCH == 8);
    end

    assert_idle_until_load_R1: assert property (@(posedge clk)
        rst |=> (pos_en == '0) && (neg_en == '0) && !com_neg && !addr_bad);

endmodule

// File: tb/test_mux_addr_decoder.sv
module test_mux_addr_decoder;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load = 1'b0;
    logic [3:0] word = 4'h0;

    logic [7:0] p8, n8;
    logic [3:0] p4, n4;
    logic       c8, b8, c4, b4;

    int compared = 0;
    int mismatched = 0;

    always #2.5 clk = ~clk;

    mux_addr_decoder #(.NCH(8)) i_mux_addr_decoder (
        .clk(clk), .rst(rst), .load(load), .mux_word(word),
        .pos_en(p8), .neg_en(n8), .com_neg(c8), .addr_bad(b8)
    );

    mux_addr_decoder #(.NCH(4)) i_mux_addr_decoder_q (
        .clk(clk), .rst(rst), .load(load), .mux_word(word),
        .pos_en(p4), .neg_en(n4), .com_neg(c4), .addr_bad(b4)
    );

    // Behavioural reference: expected routing for a word in a build of nch channels.
    function automatic void ref_route(input int nch, input logic [3:0] w,
                                      output logic [7:0] p, output logic [7:0] n,
                                      output logic c, output logic b);
        int ch;
        int pr;
        p = '0; n = '0; c = 1'b0; b = 1'b0;
        if (nch == 4 && w[1]) begin
            b = 1'b1;
        end else if (w[3]) begin
            ch = (nch == 8) ? (w[1] * 4 + w[0] * 2 + w[2]) : (w[0] * 2 + w[2]);
            p[ch] = 1'b1;
            c = 1'b1;
        end else begin
            pr = (nch == 8) ? (w[1] * 2 + w[0]) : w[0];
            p[2 * pr + (w[2] ? 1 : 0)] = 1'b1;
            n[2 * pr + (w[2] ? 0 : 1)] = 1'b1;
        end
    endfunction

    logic [7:0] ep8 = '0, en8 = '0, ep4 = '0, en4 = '0;
    logic       ec8 = 1'b0, eb8 = 1'b0, ec4 = 1'b0, eb4 = 1'b0;
    string      tag8 = "R1", tag4 = "R1";

    always @(posedge clk) begin
        logic [7:0] tp, tn;
        logic       tc, tb;
        if (rst) begin
            ep8 <= '0; en8 <= '0; ec8 <= 1'b0; eb8 <= 1'b0;
            ep4 <= '0; en4 <= '0; ec4 <= 1'b0; eb4 <= 1'b0;
            tag8 <= "R1"; tag4 <= "R1";
        end else if (load) begin
            ref_route(8, word, tp, tn, tc, tb);
            ep8 <= tp; en8 <= tn; ec8 <= tc; eb8 <= tb;
            tag8 <= word[3] ? "R2" : "R3";
            ref_route(4, word, tp, tn, tc, tb);
            ep4 <= tp; en4 <= tn; ec4 <= tc; eb4 <= tb;
            tag4 <= (!tb && eb4) ? "R7" : "R6";
        end else begin
            tag8 <= (tag8 == "R1") ? "R1" : "R4";
            tag4 <= (tag4 == "R1") ? "R1" : "R4";
        end
    end

    task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        chk(tag8, "pos8", p8, ep8);
        chk(tag8, "neg8", n8, en8);
        chk(tag8, "com8", {7'b0, c8}, {7'b0, ec8});
        chk(tag8, "bad8", {7'b0, b8}, {7'b0, eb8});
        chk(tag4, "pos4", {4'b0, p4}, ep4);
        chk(tag4, "neg4", {4'b0, n4}, en4);
        chk(tag4, "com4", {7'b0, c4}, {7'b0, ec4});
        chk(tag4, "bad4", {7'b0, b4}, {7'b0, eb4});
        // R5: at most one enable per bus, never the same channel on both
        chk("R5", "onehot8", {7'b0, ($countones(p8) <= 1 && $countones(n8) <= 1 && (p8 & n8) == 0)}, 8'h01);
        chk("R5", "onehot4", {7'b0, ($countones(p4) <= 1 && $countones(n4) <= 1 && (p4 & n4) == 0)}, 8'h01);
    end

    task automatic put(input logic [3:0] w);
        @(negedge clk);
        load = 1'b1;
        word = w;
        @(negedge clk);
        load = 1'b0;
        word = ~w; // R4: this word must be ignored
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: idle cycles with changing word and no load keep everything closed
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            word = 4'(k * 5);
        end
        for (int w = 0; w < 16; w++) put(4'(w));
        // R7: illegal word for the four-channel build followed by a legal one
        put(4'b1010);
        put(4'b1001);
        put(4'b0110);
        put(4'b0001);
        // back-to-back loads
        @(negedge clk);
        load = 1'b1;
        for (int w = 15; w >= 0; w--) begin
            word = 4'(w);
            @(negedge clk);
        end
        load = 1'b0;
        // reset mid-run, then R1 idle again
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        put(4'b1111);
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #50000;
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule